// File: doc/BRIEF.md
# Dual-Commit Reorder Buffer Scheduler

This block is the out-of-order core of a small superscalar pipeline. Each cycle the rename stage can hand it up to two renamed instructions. Each instruction names one of four functional-unit classes: integer ALU, memory, floating-point add or floating-point multiply. Each carries two source operands. A source is either an immediate value or a pending reference to the buffer entry that will produce it. The buffer keeps the instructions in program order in a circular table. The entry index is the rename tag.

When both operands of an entry hold values, the entry may issue to its unit. When several entries compete for the same unit, the oldest one issues. Results come back on independent writeback ports, each carrying a tag and a value. One writeback completes its target entry and, in the same cycle, wakes every waiting operand that refers to that tag. Completed entries leave the buffer from the oldest end, at most two per cycle.

There is no forwarding path. A result that arrives in a cycle becomes visible to issue and retirement only in the following cycle. The depth is a parameter that stands in for an unbounded buffer. When fewer than two slots are free, the block drops its accept signal so that the rename stage stalls.

Top module: `rob_sched`

## Requirements
- R1: When `ren_rdy` is high, lane 0 is accepted if `ren_vld[0]` is set, and lane 1 is accepted if both `ren_vld[1]` and `ren_vld[0]` are set. The accepted instructions receive the tags shown on `ren_tag`: `tail` for lane 0 and `tail+1` modulo DEPTH for lane 1. Tags advance sequentially modulo DEPTH.
- R2: `ren_rdy` is high exactly when at least two entries are free (occupancy at most DEPTH-2). While it is low, renamed inputs are ignored and no tag is consumed.
- R3: An entry issues only when both of its operands hold values, and it issues exactly once. The issue packet on port u carries the entry tag and both operand values, source 0 on `iss_opa` and source 1 on `iss_opb`.
- R4: Port u of the issue outputs serves unit code u, with ALU=0, MEM=1, FADD=2 and FMUL=3 (the 2-bit `ren_unit` field). At most one instruction issues per unit per cycle, and only while `fu_rdy[u]` is high. A unit with `fu_rdy` held high can take a new instruction every cycle.
- R5: When several entries of the same unit are ready, the one closest to the head (the oldest) issues.
- R6: Any number of writeback ports may be valid in one cycle. Each valid port marks the entry named by its tag complete with its value, and wakes every waiting operand whose source tag matches.
- R7: A writeback seen in cycle N can cause an issue or a retirement no earlier than cycle N+1. An instruction accepted in cycle N issues no earlier than cycle N+1.
- R8: Up to two entries retire per cycle, strictly in program order from the head. Retire lane 1 is valid only when lane 0 retires in the same cycle. The packet carries the tag, the destination register and the result value.
- R9: A pending operand is filled when its instruction is accepted if the producer entry is already complete, or if the producer is written back in that same cycle. Its value is then used at issue.
- R10: After reset the buffer is empty, `ren_rdy` is high, and no issue or retirement is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_vld | input | 2 | Renamed instruction valid per lane |
| ren_rdy | output | 1 | At least two free entries; accept allowed |
| ren_tag | output | 2*TAG_W | Tags given to lane 0 (low) and lane 1 (high) |
| ren_unit | input | 4 | Unit code per lane, 2 bits each |
| ren_dst | input | 2*AREG_W | Architectural destination per lane |
| ren_pend | input | 4 | Operand pending flag, bit lane*2+src |
| ren_stag | input | 4*TAG_W | Producer tag per operand, index lane*2+src |
| ren_sval | input | 4*DATA_W | Immediate operand value, index lane*2+src |
| fu_rdy | input | 4 | Unit accepts an instruction this cycle |
| iss_vld | output | 4 | Issue valid per unit |
| iss_tag | output | 4*TAG_W | Tag of the issued entry per unit |
| iss_opa | output | 4*DATA_W | Source 0 value per unit |
| iss_opb | output | 4*DATA_W | Source 1 value per unit |
| wb_vld | input | NUM_WB | Writeback valid per port |
| wb_tag | input | NUM_WB*TAG_W | Writeback target tag per port |
| wb_val | input | NUM_WB*DATA_W | Writeback result per port |
| ret_vld | output | 2 | Retire valid, lane 0 oldest |
| ret_tag | output | 2*TAG_W | Tag of each retiring entry |
| ret_dst | output | 2*AREG_W | Destination register of each retiring entry |
| ret_val | output | 2*DATA_W | Result value of each retiring entry |

## Verification
The delicate overlap is a writeback landing in the same cycle as the acceptance of an instruction that depends on it. The same overlap arises when a writeback lands just as that producer would otherwise reach the head. Both must see the value one cycle later and never in the same cycle. The bench provokes this by making the next instruction, or the one after, depend on its predecessor while the ALU returns results after a single cycle. It also runs phases with all units stalled, so that many writebacks then arrive together. A behavioural model built on sequence numbers predicts every issue and retirement packet from operand arrival alone, and any early or late packet shows up as a mismatch in that cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        FU_ALU  = 2'd0,
        FU_MEM  = 2'd1,
        FU_FADD = 2'd2,
        FU_FMUL = 2'd3
    } fu_e;

    localparam int NUM_FU  = 4;
    localparam int NUM_SRC = 2;
    localparam int LANES   = 2;

    function automatic logic [1:0] lane_count(input logic [LANES-1:0] v);
        return {1'b0, v[0]} + {1'b0, v[1]};
    endfunction

endpackage

// File: rtl/rob_alloc.sv
module rob_alloc
    import rob_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] ren_vld,
    input  logic [1:0]       ret_n,
    output logic             ren_rdy,
    output logic [LANES-1:0] push,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail
);

    logic [CNT_W-1:0] count_q;
    logic [TAG_W-1:0] head_q, tail_q;
    logic [1:0]       n_push;

    assign ren_rdy = (count_q <= CNT_W'(DEPTH - 2));
    assign push[0] = ren_rdy & ren_vld[0];
    assign push[1] = push[0] & ren_vld[1];
    assign n_push  = lane_count(push);
    assign head    = head_q;
    assign tail    = tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            count_q <= count_q + CNT_W'(n_push) - CNT_W'(ret_n);
            head_q  <= head_q + TAG_W'(ret_n);
            tail_q  <= tail_q + TAG_W'(n_push);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH))
        else $error("occupancy above depth"); // R2

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ren_rdy && ret_n == 2'd0) |=> (count_q == $past(count_q) && tail_q == $past(tail_q)))
        else $error("input taken while not ready"); // R2

endmodule

// File: rtl/rob_age_pick.sv
module rob_age_pick #(
    parameter  int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    input  logic [TAG_W-1:0] base,
    output logic             gnt,
    output logic [TAG_W-1:0] idx
);

    logic [TAG_W-1:0] probe;

    // Scan from youngest offset down to the head so the oldest hit wins.
    always_comb begin
        gnt   = 1'b0;
        idx   = base;
        probe = base;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            probe = base + TAG_W'(k);
            if (req[probe]) begin
                gnt = 1'b1;
                idx = probe;
            end
        end
    end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
    parameter  int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] live,
    input  logic [DEPTH-1:0] fin,
    input  logic [TAG_W-1:0] head,
    output logic [1:0]       ret_vld,
    output logic [1:0]       ret_n,
    output logic [TAG_W-1:0] head_nx
);

    always_comb begin
        head_nx    = head + TAG_W'(1);
        ret_vld[0] = live[head] & fin[head];
        ret_vld[1] = ret_vld[0] & live[head_nx] & fin[head_nx];
        ret_n      = {1'b0, ret_vld[0]} + {1'b0, ret_vld[1]};
    end

endmodule

// File: rtl/rob_sched.sv
module rob_sched
    import rob_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int DATA_W = 16,
    parameter  int AREG_W = 5,
    parameter  int NUM_WB = 4,
    localparam int TAG_W  = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LANES-1:0]           ren_vld,
    output logic                       ren_rdy,
    output logic [LANES*TAG_W-1:0]     ren_tag,
    input  logic [LANES*2-1:0]         ren_unit,
    input  logic [LANES*AREG_W-1:0]    ren_dst,
    input  logic [LANES*NUM_SRC-1:0]   ren_pend,
    input  logic [LANES*NUM_SRC*TAG_W-1:0]  ren_stag,
    input  logic [LANES*NUM_SRC*DATA_W-1:0] ren_sval,
    input  logic [NUM_FU-1:0]          fu_rdy,
    output logic [NUM_FU-1:0]          iss_vld,
    output logic [NUM_FU*TAG_W-1:0]    iss_tag,
    output logic [NUM_FU*DATA_W-1:0]   iss_opa,
    output logic [NUM_FU*DATA_W-1:0]   iss_opb,
    input  logic [NUM_WB-1:0]          wb_vld,
    input  logic [NUM_WB*TAG_W-1:0]    wb_tag,
    input  logic [NUM_WB*DATA_W-1:0]   wb_val,
    output logic [LANES-1:0]           ret_vld,
    output logic [LANES*TAG_W-1:0]     ret_tag,
    output logic [LANES*AREG_W-1:0]    ret_dst,
    output logic [LANES*DATA_W-1:0]    ret_val
);

    typedef struct packed {
        logic                             vld;
        logic                             iss;
        logic                             done;
        fu_e                              unit;
        logic [AREG_W-1:0]                dst;
        logic [NUM_SRC-1:0]               pend;
        logic [NUM_SRC-1:0][TAG_W-1:0]    stag;
        logic [NUM_SRC-1:0][DATA_W-1:0]   sval;
        logic [DATA_W-1:0]                res;
    } ent_t;

    ent_t ent_q   [DEPTH];
    ent_t ent_d   [DEPTH];
    ent_t new_ent [LANES];

    logic [TAG_W-1:0]  wb_tag_a [NUM_WB];
    logic [DATA_W-1:0] wb_val_a [NUM_WB];

    logic [LANES-1:0]  push;
    logic [TAG_W-1:0]  head, tail, head_nx;
    logic [1:0]        ret_n;
    logic [TAG_W-1:0]  slot_tag [LANES];
    logic [DEPTH-1:0]  live, fin;
    logic [DEPTH-1:0]  req      [NUM_FU];
    logic              pick_vld [NUM_FU];
    logic [TAG_W-1:0]  pick_idx [NUM_FU];

    // ---------------- allocation and retirement ----------------
    rob_alloc #(.DEPTH(DEPTH)) u_alloc (
        .clk     (clk),
        .rst     (rst),
        .ren_vld (ren_vld),
        .ret_n   (ret_n),
        .ren_rdy (ren_rdy),
        .push    (push),
        .head    (head),
        .tail    (tail)
    );

    rob_retire_sel #(.DEPTH(DEPTH)) u_retire (
        .live    (live),
        .fin     (fin),
        .head    (head),
        .ret_vld (ret_vld),
        .ret_n   (ret_n),
        .head_nx (head_nx)
    );

    always_comb begin
        for (int w = 0; w < NUM_WB; w++) begin
            wb_tag_a[w] = wb_tag[w*TAG_W +: TAG_W];
            wb_val_a[w] = wb_val[w*DATA_W +: DATA_W];
        end
        for (int i = 0; i < DEPTH; i++) begin
            live[i] = ent_q[i].vld;
            fin[i]  = ent_q[i].done;
        end
        for (int k = 0; k < LANES; k++) begin
            slot_tag[k] = tail + TAG_W'(k);
        end
    end

    assign ren_tag = {slot_tag[1], slot_tag[0]};
    assign ret_tag = {head_nx, head};
    assign ret_dst = {ent_q[head_nx].dst, ent_q[head].dst};
    assign ret_val = {ent_q[head_nx].res, ent_q[head].res};

    // ---------------- new entries with operand capture ----------------
    always_comb begin
        logic [TAG_W-1:0] tg;
        tg = '0;
        for (int k = 0; k < LANES; k++) begin
            new_ent[k]      = '0;
            new_ent[k].vld  = 1'b1;
            new_ent[k].unit = fu_e'(ren_unit[k*2 +: 2]);
            new_ent[k].dst  = ren_dst[k*AREG_W +: AREG_W];
            for (int s = 0; s < NUM_SRC; s++) begin
                tg                 = ren_stag[(k*NUM_SRC+s)*TAG_W +: TAG_W];
                new_ent[k].pend[s] = ren_pend[k*NUM_SRC+s];
                new_ent[k].stag[s] = tg;
                new_ent[k].sval[s] = ren_sval[(k*NUM_SRC+s)*DATA_W +: DATA_W];
                if (ren_pend[k*NUM_SRC+s]) begin
                    if (ent_q[tg].vld && ent_q[tg].done) begin
                        new_ent[k].pend[s] = 1'b0;
                        new_ent[k].sval[s] = ent_q[tg].res;
                    end
                    for (int w = 0; w < NUM_WB; w++) begin
                        if (wb_vld[w] && wb_tag_a[w] == tg) begin
                            new_ent[k].pend[s] = 1'b0;
                            new_ent[k].sval[s] = wb_val_a[w];
                        end
                    end
                end
            end
        end
    end

    // ---------------- per-unit oldest-ready selection ----------------
    genvar gu;
    generate
        for (gu = 0; gu < NUM_FU; gu++) begin : g_unit
            always_comb begin
                for (int i = 0; i < DEPTH; i++) begin
                    req[gu][i] = ent_q[i].vld && !ent_q[i].iss &&
                                 (ent_q[i].pend == '0) && (ent_q[i].unit == fu_e'(2'(gu)));
                end
            end

            rob_age_pick #(.DEPTH(DEPTH)) u_pick (
                .req  (req[gu]),
                .base (head),
                .gnt  (pick_vld[gu]),
                .idx  (pick_idx[gu])
            );

            assign iss_vld[gu]                   = pick_vld[gu] & fu_rdy[gu];
            assign iss_tag[gu*TAG_W +: TAG_W]    = pick_idx[gu];
            assign iss_opa[gu*DATA_W +: DATA_W]  = ent_q[pick_idx[gu]].sval[0];
            assign iss_opb[gu*DATA_W +: DATA_W]  = ent_q[pick_idx[gu]].sval[1];

            AST_ISSUE_READY: assert property (@(posedge clk) disable iff (rst)
                iss_vld[gu] |-> (ent_q[pick_idx[gu]].vld && !ent_q[pick_idx[gu]].iss &&
                                 ent_q[pick_idx[gu]].pend == '0 &&
                                 ent_q[pick_idx[gu]].unit == fu_e'(2'(gu))))
                else $error("issue of an entry that is not ready"); // R3
        end
    endgenerate

    // ---------------- next-state of the entry table ----------------
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
            if ((ret_vld[0] && head == TAG_W'(i)) || (ret_vld[1] && head_nx == TAG_W'(i))) begin
                ent_d[i].vld = 1'b0;
            end
            for (int u = 0; u < NUM_FU; u++) begin
                if (iss_vld[u] && pick_idx[u] == TAG_W'(i)) begin
                    ent_d[i].iss = 1'b1;
                end
            end
            for (int w = 0; w < NUM_WB; w++) begin
                if (wb_vld[w] && ent_q[i].vld) begin
                    if (wb_tag_a[w] == TAG_W'(i)) begin
                        ent_d[i].done = 1'b1;
                        ent_d[i].res  = wb_val_a[w];
                    end
                    for (int s = 0; s < NUM_SRC; s++) begin
                        if (ent_q[i].pend[s] && ent_q[i].stag[s] == wb_tag_a[w]) begin
                            ent_d[i].pend[s] = 1'b0;
                            ent_d[i].sval[s] = wb_val_a[w];
                        end
                    end
                end
            end
            for (int k = 0; k < LANES; k++) begin
                if (push[k] && slot_tag[k] == TAG_W'(i)) begin
                    ent_d[i] = new_ent[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    // ---------------- checks on the surrounding pipeline ----------------
    genvar gw;
    generate
        for (gw = 0; gw < NUM_WB; gw++) begin : g_wbchk
            AST_WB_LIVE: assert property (@(posedge clk) disable iff (rst)
                wb_vld[gw] |-> (ent_q[wb_tag_a[gw]].vld && ent_q[wb_tag_a[gw]].iss &&
                                !ent_q[wb_tag_a[gw]].done))
                else $error("writeback to an entry not in flight"); // R6
        end
    endgenerate

    AST_RETIRE_DONE: assert property (@(posedge clk) disable iff (rst)
        ret_vld[0] |-> (ent_q[head].vld && ent_q[head].done && ent_q[head].iss))
        else $error("retirement of an incomplete entry"); // R8

endmodule

// File: tb/rob_sched_tb.sv
`timescale 1ns/1ps
module rob_sched_tb_top;

    localparam int D   = 8;
    localparam int TW  = 3;
    localparam int DW  = 16;
    localparam int AW  = 5;
    localparam int NWB = 4;
    localparam int MAXN = 1024;
    localparam real HALF = 10.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(HALF) clk = ~clk;

    logic [1:0]        ren_vld = '0;
    logic              ren_rdy;
    logic [2*TW-1:0]   ren_tag;
    logic [3:0]        ren_unit = '0;
    logic [2*AW-1:0]   ren_dst = '0;
    logic [3:0]        ren_pend = '0;
    logic [4*TW-1:0]   ren_stag = '0;
    logic [4*DW-1:0]   ren_sval = '0;
    logic [3:0]        fu_rdy = '0;
    logic [3:0]        iss_vld;
    logic [4*TW-1:0]   iss_tag;
    logic [4*DW-1:0]   iss_opa, iss_opb;
    logic [NWB-1:0]    wb_vld = '0;
    logic [NWB*TW-1:0] wb_tag = '0;
    logic [NWB*DW-1:0] wb_val = '0;
    logic [1:0]        ret_vld;
    logic [2*TW-1:0]   ret_tag;
    logic [2*AW-1:0]   ret_dst;
    logic [2*DW-1:0]   ret_val;

    rob_sched #(.DEPTH(D), .DATA_W(DW), .AREG_W(AW), .NUM_WB(NWB)) dut_i (
        .clk(clk), .rst(rst),
        .ren_vld(ren_vld), .ren_rdy(ren_rdy), .ren_tag(ren_tag), .ren_unit(ren_unit),
        .ren_dst(ren_dst), .ren_pend(ren_pend), .ren_stag(ren_stag), .ren_sval(ren_sval),
        .fu_rdy(fu_rdy), .iss_vld(iss_vld), .iss_tag(iss_tag), .iss_opa(iss_opa), .iss_opb(iss_opb),
        .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_val(wb_val),
        .ret_vld(ret_vld), .ret_tag(ret_tag), .ret_dst(ret_dst), .ret_val(ret_val)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // behavioural model, indexed by program sequence number
    int          m_unit [MAXN];
    int          m_dst  [MAXN];
    bit          m_pend [MAXN][2];
    int          m_prod [MAXN][2];
    logic [15:0] m_sval [MAXN][2];
    bit          m_iss  [MAXN];
    bit          m_done [MAXN];
    logic [15:0] m_res  [MAXN];
    int          hd = 0;
    int          nx = 0;

    // functional-unit pipes: slot (cycle mod 8) holds the sequence to write back
    int          pq_seq [4][8];
    logic [15:0] pq_val [4][8];
    int          lat    [4] = '{1, 2, 3, 4};

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    function automatic bit src_ready(input int s, input int j);
        return !m_pend[s][j] || m_done[m_prod[s][j]];
    endfunction

    function automatic logic [15:0] src_val(input int s, input int j);
        return m_pend[s][j] ? m_res[m_prod[s][j]] : m_sval[s][j];
    endfunction

    // mode 0: random units, 1: units stalled, 2: units always ready, 3: drain
    task automatic step(input int mode);
        int          offer;
        bit          rdy_e;
        int          g_unit [2];
        int          g_dst  [2];
        bit          g_pend [2][2];
        int          g_prod [2][2];
        logic [15:0] g_val  [2][2];
        bit          ex_hit [4];
        int          ex_seq [4];
        bit          c0, c1;
        int          wseq   [4];

        for (int u = 0; u < 4; u++) begin
            fu_rdy[u] = (mode == 1) ? 1'b0 : (mode == 0) ? (($urandom % 4) != 0) : 1'b1;
        end

        wb_vld = '0;
        for (int u = 0; u < 4; u++) begin
            wseq[u] = pq_seq[u][cyc % 8];
            if (wseq[u] >= 0) begin
                wb_vld[u]           = 1'b1;
                wb_tag[u*TW +: TW]  = TW'(wseq[u] % D);
                wb_val[u*DW +: DW]  = pq_val[u][cyc % 8];
                pq_seq[u][cyc % 8]  = -1;
            end
        end

        rdy_e = (nx - hd) <= D - 2;
        offer = (mode == 3) ? 0 : (mode == 1) ? 2 : int'($urandom % 3);
        ren_vld = '0;
        for (int k = 0; k < offer; k++) begin
            int s;
            s = nx + k;
            g_unit[k] = int'($urandom % 4);
            g_dst[k]  = int'($urandom % 32);
            for (int j = 0; j < 2; j++) begin
                int p;
                g_pend[k][j] = 1'b0;
                g_prod[k][j] = 0;
                g_val[k][j]  = 16'($urandom);
                if (s > 0 && ($urandom % 3) != 0) begin
                    p = s - 1 - int'($urandom % 4);
                    if (p < 0) p = 0;
                    if (p < hd) begin
                        g_val[k][j] = m_res[p];
                    end else begin
                        g_pend[k][j] = 1'b1;
                        g_prod[k][j] = p;
                    end
                end
                ren_pend[k*2+j]              = g_pend[k][j];
                ren_stag[(k*2+j)*TW +: TW]   = TW'(g_prod[k][j] % D);
                ren_sval[(k*2+j)*DW +: DW]   = g_val[k][j];
            end
            ren_unit[k*2 +: 2]  = 2'(g_unit[k]);
            ren_dst[k*AW +: AW] = AW'(g_dst[k]);
            ren_vld[k]          = 1'b1;
        end

        #1;
        // expectations from the model state before this clock edge
        chk(ren_rdy == rdy_e, "R2 accept-ready", int'(ren_rdy), int'(rdy_e));
        if (rdy_e) begin
            chk(ren_tag[0 +: TW] == TW'(nx % D) && ren_tag[TW +: TW] == TW'((nx + 1) % D),
                "R1 allocated tags", int'(ren_tag), ((nx + 1) % D) * 8 + nx % D);
        end
        for (int u = 0; u < 4; u++) begin
            ex_hit[u] = 1'b0;
            ex_seq[u] = -1;
            for (int s = hd; s < nx; s++) begin
                if (!ex_hit[u] && m_unit[s] == u && !m_iss[s] && src_ready(s, 0) && src_ready(s, 1)) begin
                    ex_hit[u] = 1'b1;
                    ex_seq[u] = s;
                end
            end
            ex_hit[u] = ex_hit[u] && fu_rdy[u];
            chk(iss_vld[u] == ex_hit[u], "R4 R5 R7 issue valid", int'(iss_vld[u]), int'(ex_hit[u]));
            if (ex_hit[u] && iss_vld[u]) begin
                chk(iss_tag[u*TW +: TW] == TW'(ex_seq[u] % D), "R5 oldest-ready tag",
                    int'(iss_tag[u*TW +: TW]), ex_seq[u] % D);
                chk(iss_opa[u*DW +: DW] == src_val(ex_seq[u], 0) &&
                    iss_opb[u*DW +: DW] == src_val(ex_seq[u], 1), "R3 R9 operand values",
                    int'(iss_opa[u*DW +: DW]), int'(src_val(ex_seq[u], 0)));
            end
        end
        c0 = (hd < nx) && m_done[hd];
        c1 = c0 && (hd + 1 < nx) && m_done[hd + 1];
        chk(ret_vld[0] == c0, "R7 R8 retire lane 0", int'(ret_vld[0]), int'(c0));
        chk(ret_vld[1] == c1, "R8 retire lane 1", int'(ret_vld[1]), int'(c1));
        if (c0 && ret_vld[0]) begin
            chk(ret_tag[0 +: TW] == TW'(hd % D) && ret_val[0 +: DW] == m_res[hd] &&
                ret_dst[0 +: AW] == AW'(m_dst[hd]), "R6 R8 retire packet 0",
                int'(ret_val[0 +: DW]), int'(m_res[hd]));
        end
        if (c1 && ret_vld[1]) begin
            chk(ret_tag[TW +: TW] == TW'((hd + 1) % D) && ret_val[DW +: DW] == m_res[hd + 1] &&
                ret_dst[AW +: AW] == AW'(m_dst[hd + 1]), "R6 R8 retire packet 1",
                int'(ret_val[DW +: DW]), int'(m_res[hd + 1]));
        end

        // model update for the coming edge
        for (int u = 0; u < 4; u++) begin
            if (ex_hit[u]) begin
                int slot;
                slot = (cyc + lat[u]) % 8;
                m_iss[ex_seq[u]] = 1'b1;
                pq_seq[u][slot]  = ex_seq[u];
                pq_val[u][slot]  = 16'(src_val(ex_seq[u], 0) * 3 + src_val(ex_seq[u], 1) + u + 1);
            end
        end
        for (int u = 0; u < 4; u++) begin
            if (wseq[u] >= 0) begin
                m_done[wseq[u]] = 1'b1;
                m_res[wseq[u]]  = wb_val[u*DW +: DW];
            end
        end
        hd = hd + int'(c0) + int'(c1);
        if (rdy_e) begin
            for (int k = 0; k < offer; k++) begin
                m_unit[nx + k] = g_unit[k];
                m_dst[nx + k]  = g_dst[k];
                for (int j = 0; j < 2; j++) begin
                    m_pend[nx + k][j] = g_pend[k][j];
                    m_prod[nx + k][j] = g_prod[k][j];
                    m_sval[nx + k][j] = g_val[k][j];
                end
            end
            nx = nx + offer;
        end

        cyc++;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 400);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int u = 0; u < 4; u++) begin
            for (int i = 0; i < 8; i++) pq_seq[u][i] = -1;
        end
        for (int i = 0; i < MAXN; i++) begin
            m_iss[i] = 1'b0;
            m_done[i] = 1'b0;
            m_res[i] = '0;
        end
        fu_rdy = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        chk(ren_rdy == 1'b1, "R10 ready after reset", int'(ren_rdy), 1);
        chk(iss_vld == 4'b0, "R10 no issue after reset", int'(iss_vld), 0);
        chk(ret_vld == 2'b0, "R10 no retire after reset", int'(ret_vld), 0);
        @(negedge clk);

        repeat (150) step(0);
        repeat (30)  step(1);   // fill until full, R2 ignore
        repeat (80)  step(2);   // burst of writebacks after stall
        repeat (30)  step(1);
        repeat (80)  step(0);
        repeat (40)  step(3);   // drain

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule